// File: doc/BRIEF.md
# Serial Flash Write-Protection Gate

This block decides, for every instruction that a serial NOR flash slave receives, whether the instruction may take effect. An SPI front end shifts the bits in and presents the decoded 8-bit opcode, together with a flag that says whether the full bit count arrived. The gate judges the instruction at the moment chip select returns high. It answers with a one-cycle accept or reject pulse. The array sequencer starts work only on an accepted program, erase or status write, and it reports completion with a pulse.

The gate keeps the state that write protection depends on: the write-enable latch, the power-down flag and an array-busy flag. It also runs a lockout timer that starts once the digital power-good input rises. The status-register protect field and the write-protect pin come in from outside. A low power-good input holds all of this state cleared. A chip-select release while hold is active, or an instruction with an incomplete bit count, is thrown away with no verdict and no side effect.

Top module: `flash_wp_gate`

## Requirements
- R1: While `pwr_good` is low, every complete instruction gets `cmd_reject`. One clock later `wel`, `pd_active` and `array_busy` are 0, and they stay 0 for as long as `pwr_good` stays low.
- R2: For `LOCKOUT_CYCLES` clock edges after `pwr_good` is first sampled high, these instructions are rejected: write enable, page program, all erases and status write. Read-class instructions and write disable are still accepted.
- R3: Page program, erases and status write are accepted only while `wel` is 1. An accepted write enable sets `wel` to 1.
- R4: An `op_done` pulse while `array_busy` is 1 clears both `array_busy` and `wel` on the next clock.
- R5: An accepted deep power-down sets `pd_active`. While it is set, every instruction except release-power-down is rejected and changes nothing. An accepted release clears `pd_active`.
- R6: Status write is rejected, whatever `wel` holds, in two cases: `sr_protect` is 2'b01 and `wp_n` is 0, or `sr_protect[1]` is 1. With `sr_protect` 2'b00, `wp_n` has no effect.
- R7: If `hold_n` is 0 on the clock edge where chip select is first seen high, the instruction is dropped. No accept or reject pulse follows, and no state changes.
- R8: An instruction that ends with `cmd_whole` low is dropped. No accept or reject pulse follows, and no state changes.
- R9: An accepted write disable clears `wel` at once. A rejected instruction leaves `wel` unchanged.
- R10: An accepted program, erase or status write sets `array_busy`. While it is set, program, erase, status write and deep power-down are rejected. Write enable is still accepted.
- R11: The verdict for a complete instruction comes on the first clock edge that samples `cs_n` high after it was low. It is exactly one of `cmd_accept` or `cmd_reject`, it is high for one cycle, and it appears in the cycle after that edge.
- R12: Opcode encodings:
  - 8'h06 write enable
  - 8'h04 write disable
  - 8'h02 page program
  - 8'h20, 8'h52, 8'hD8 and 8'hC7 erase
  - 8'h01 status write
  - 8'hB9 deep power-down
  - 8'hAB release power-down
  - every other code is read-class and is accepted unless power-down, power-good or reset blocks it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Digital power-good indication; low holds the protection state cleared |
| cs_n | input | 1 | Chip select, active low; the rising edge ends an instruction |
| hold_n | input | 1 | Hold, active low |
| cmd_code | input | 8 | Decoded opcode from the SPI front end |
| cmd_whole | input | 1 | High when the instruction's full bit count was received |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| sr_protect | input | 2 | Status-register protect field |
| op_done | input | 1 | Completion pulse from the array sequencer |
| cmd_accept | output | 1 | One-cycle accept verdict |
| cmd_reject | output | 1 | One-cycle reject verdict |
| wel | output | 1 | Write-enable latch |
| pd_active | output | 1 | Deep power-down state |
| array_busy | output | 1 | An accepted program, erase or status write is in progress |

## Verification
The main test sweeps all eleven opcodes of interest. It repeats the sweep for every `sr_protect` value and both `wp_n` levels, and alternates whether a write enable goes before each opcode. This separates acceptance that depends on the latch from acceptance that depends on the pin and protect field. Directed sequences cover the states the sweep cannot reach by itself: power-good low, the lockout window, a busy array with a second write, power-down, and frames dropped by hold or by a short bit count. In each of these the verdict pulse and all three state outputs are compared with a model kept inside the bench.

// File: rtl/fwg_pkg.sv
// Package: opcode encodings and instruction classes shared by the gate.
// Assumes opcodes arrive fully decoded as 8-bit values.
package fwg_pkg;

    localparam int OPW = 8;

    typedef enum logic [2:0] {
        CL_OTHER,
        CL_WREN,
        CL_WRDI,
        CL_PROG,
        CL_ERASE,
        CL_WRSR,
        CL_DPD,
        CL_RDP
    } cmd_class_t;

    localparam logic [OPW-1:0] OP_WREN = 8'h06;
    localparam logic [OPW-1:0] OP_WRDI = 8'h04;
    localparam logic [OPW-1:0] OP_PROG = 8'h02;
    localparam logic [OPW-1:0] OP_WRSR = 8'h01;
    localparam logic [OPW-1:0] OP_DPD  = 8'hB9;
    localparam logic [OPW-1:0] OP_RDP  = 8'hAB;

    localparam int NUM_ERASE = 4;
    localparam logic [NUM_ERASE*OPW-1:0] ERASE_OPS = {8'hC7, 8'hD8, 8'h52, 8'h20};

    // Maps an opcode to its protection class.
    function automatic cmd_class_t classify(input logic [OPW-1:0] op);
        cmd_class_t cls;
        cls = CL_OTHER;
        case (op)
            OP_WREN: cls = CL_WREN;
            OP_WRDI: cls = CL_WRDI;
            OP_PROG: cls = CL_PROG;
            OP_WRSR: cls = CL_WRSR;
            OP_DPD:  cls = CL_DPD;
            OP_RDP:  cls = CL_RDP;
            default: cls = CL_OTHER;
        endcase
        for (int i = 0; i < NUM_ERASE; i++) begin
            if (op == ERASE_OPS[i*OPW +: OPW]) cls = CL_ERASE;
        end
        return cls;
    endfunction

endpackage

// File: rtl/fwg_lockout_timer.sv
// Power-up lockout timer.
// Counts clock edges with pwr_good high and reports the lockout as active
// until LOCKOUT_CYCLES edges have passed. Reset or pwr_good low restarts it.
// Assumes LOCKOUT_CYCLES >= 1.
module fwg_lockout_timer #(
    parameter int LOCKOUT_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    output logic lock_active
);
    localparam int CW = $clog2(LOCKOUT_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(LOCKOUT_CYCLES);

    logic [CW-1:0] cnt;

    // Count up to the limit once power is good; restart otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_good) begin
            cnt <= '0;
        end else if (cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Lockout stays active until the limit is reached.
    always_comb lock_active = (cnt != LIMIT);

endmodule

// File: rtl/fwg_frame_end.sv
// Instruction-end detector.
// Finds the first clock edge that samples cs_n high after it was low. It
// marks the instruction valid only if hold was inactive and the front end
// flagged a full bit count. Assumes cs_n is already synchronous to clk.
module fwg_frame_end (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic hold_n,
    input  logic cmd_whole,
    output logic frame_valid
);
    logic cs_q;

    // Remember the previous chip-select level (idle high).
    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= 1'b1;
        else        cs_q <= cs_n;
    end

    // A rising chip select with hold released and a full bit count ends a usable instruction.
    always_comb frame_valid = cs_n && !cs_q && hold_n && cmd_whole;

endmodule

// File: rtl/fwg_policy.sv
// Acceptance policy.
// A purely combinational verdict for one instruction, taken from the
// current protection state. It also gives the state-update strobes, which
// are qualified by frame_valid and by acceptance.
module fwg_policy
    import fwg_pkg::*;
(
    input  logic [OPW-1:0] cmd_code,
    input  logic           frame_valid,
    input  logic           pwr_good,
    input  logic           lock_active,
    input  logic           wel,
    input  logic           pd_active,
    input  logic           array_busy,
    input  logic           wp_n,
    input  logic [1:0]     sr_protect,
    output logic           allow,
    output logic           set_wel,
    output logic           clr_wel,
    output logic           start_op,
    output logic           set_pd,
    output logic           clr_pd
);
    cmd_class_t cls;
    logic       sr_locked;
    logic       write_ok;
    logic       take;

    // Classify the opcode and work out the status-register lock.
    always_comb begin
        cls       = classify(cmd_code);
        sr_locked = sr_protect[1] || (sr_protect == 2'b01 && !wp_n);
        write_ok  = !lock_active && wel && !array_busy;
    end

    // Verdict: power first, then power-down, then per-class rules.
    always_comb begin
        allow = 1'b0;
        if (!pwr_good) begin
            allow = 1'b0;
        end else if (pd_active) begin
            allow = (cls == CL_RDP);
        end else begin
            case (cls)
                CL_WREN:           allow = !lock_active;
                CL_PROG, CL_ERASE: allow = write_ok;
                CL_WRSR:           allow = write_ok && !sr_locked;
                CL_DPD:            allow = !array_busy;
                default:           allow = 1'b1;
            endcase
        end
    end

    // State-update strobes for an accepted instruction.
    always_comb begin
        take     = frame_valid && allow;
        set_wel  = take && (cls == CL_WREN);
        clr_wel  = take && (cls == CL_WRDI);
        start_op = take && (cls == CL_PROG || cls == CL_ERASE || cls == CL_WRSR);
        set_pd   = take && (cls == CL_DPD);
        clr_pd   = take && (cls == CL_RDP);
    end

endmodule

// File: rtl/flash_wp_gate.sv
// Serial flash write-protection gate (top).
// Gives an accept/reject verdict on every complete instruction and holds
// the write-enable latch, the power-down flag and the array-busy flag.
// Assumes all inputs are synchronous to clk and rst_n is synchronous and
// active low.
module flash_wp_gate
    import fwg_pkg::*;
#(
    parameter int LOCKOUT_CYCLES = 1000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pwr_good,
    input  logic           cs_n,
    input  logic           hold_n,
    input  logic [OPW-1:0] cmd_code,
    input  logic           cmd_whole,
    input  logic           wp_n,
    input  logic [1:0]     sr_protect,
    input  logic           op_done,
    output logic           cmd_accept,
    output logic           cmd_reject,
    output logic           wel,
    output logic           pd_active,
    output logic           array_busy
);
    logic lock_active;
    logic frame_valid;
    logic allow;
    logic set_wel, clr_wel, start_op, set_pd, clr_pd;
    logic done_hit;

    fwg_lockout_timer #(.LOCKOUT_CYCLES(LOCKOUT_CYCLES)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_good    (pwr_good),
        .lock_active (lock_active)
    );

    fwg_frame_end u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .hold_n      (hold_n),
        .cmd_whole   (cmd_whole),
        .frame_valid (frame_valid)
    );

    fwg_policy u_policy (
        .cmd_code    (cmd_code),
        .frame_valid (frame_valid),
        .pwr_good    (pwr_good),
        .lock_active (lock_active),
        .wel         (wel),
        .pd_active   (pd_active),
        .array_busy  (array_busy),
        .wp_n        (wp_n),
        .sr_protect  (sr_protect),
        .allow       (allow),
        .set_wel     (set_wel),
        .clr_wel     (clr_wel),
        .start_op    (start_op),
        .set_pd      (set_pd),
        .clr_pd      (clr_pd)
    );

    // A completion only counts while an operation is in progress.
    always_comb done_hit = op_done && array_busy;

    // Register the one-cycle verdict pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_accept <= 1'b0;
            cmd_reject <= 1'b0;
        end else begin
            cmd_accept <= frame_valid && allow;
            cmd_reject <= frame_valid && !allow;
        end
    end

    // Write-enable latch: a new enable wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_good)      wel <= 1'b0;
        else if (set_wel)             wel <= 1'b1;
        else if (clr_wel || done_hit) wel <= 1'b0;
    end

    // Array-busy flag: set by an accepted write, cleared by completion.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_good) array_busy <= 1'b0;
        else if (start_op)       array_busy <= 1'b1;
        else if (done_hit)       array_busy <= 1'b0;
    end

    // Power-down flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_good) pd_active <= 1'b0;
        else if (set_pd)         pd_active <= 1'b1;
        else if (clr_pd)         pd_active <= 1'b0;
    end

endmodule

// File: rtl/fwg_checker.sv
// Property checker for flash_wp_gate, attached with bind.
module fwg_checker (
    input logic clk,
    input logic rst_n,
    input logic pwr_good,
    input logic op_done,
    input logic cmd_accept,
    input logic cmd_reject,
    input logic wel,
    input logic pd_active,
    input logic array_busy
);
    // R11: never both verdicts at once.
    assert_one_verdict_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_accept && cmd_reject));

    // R1: power-good low clears all protection state.
    assert_pg_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (!wel && !pd_active && !array_busy));

    // R3: the latch only rises with an accepted instruction.
    assert_wel_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> cmd_accept);

    // R10: an operation only starts from an accepted instruction with the latch set.
    assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(array_busy) |-> (cmd_accept && $past(wel)));

    // R4: completion ends the busy state.
    assert_done_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (array_busy && op_done) |=> !array_busy);

    // R5: power-down is left only through an accepted release or power loss.
    assert_pd_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pd_active) && $past(pwr_good)) |-> cmd_accept);

endmodule

bind flash_wp_gate fwg_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_good   (pwr_good),
    .op_done    (op_done),
    .cmd_accept (cmd_accept),
    .cmd_reject (cmd_reject),
    .wel        (wel),
    .pd_active  (pd_active),
    .array_busy (array_busy)
);

// File: tb/flash_wp_gate_tb.sv
module flash_wp_gate_tb;
    localparam int LOCK = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_good = 1'b0;
    logic       cs_n = 1'b1;
    logic       hold_n = 1'b1;
    logic [7:0] cmd_code = 8'h00;
    logic       cmd_whole = 1'b1;
    logic       wp_n = 1'b1;
    logic [1:0] sr_protect = 2'b00;
    logic       op_done = 1'b0;
    logic       cmd_accept, cmd_reject, wel, pd_active, array_busy;

    int checks = 0;
    int errors = 0;

    // bench model of the protection state
    bit m_pg = 0, m_lock = 1, m_wel = 0, m_pd = 0, m_busy = 0;

    always #2 clk = ~clk;

    flash_wp_gate #(.LOCKOUT_CYCLES(LOCK)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .cs_n(cs_n),
        .hold_n(hold_n), .cmd_code(cmd_code), .cmd_whole(cmd_whole),
        .wp_n(wp_n), .sr_protect(sr_protect), .op_done(op_done),
        .cmd_accept(cmd_accept), .cmd_reject(cmd_reject), .wel(wel),
        .pd_active(pd_active), .array_busy(array_busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_state(input string req);
        chk(wel == m_wel, req, "wel", int'(wel), int'(m_wel));
        chk(pd_active == m_pd, req, "pd_active", int'(pd_active), int'(m_pd));
        chk(array_busy == m_busy, req, "array_busy", int'(array_busy), int'(m_busy));
    endtask

    function automatic bit is_erase(input logic [7:0] op);
        return op == 8'h20 || op == 8'h52 || op == 8'hD8 || op == 8'hC7;
    endfunction

    // R12 encodings; verdict from R1..R10
    function automatic bit model_accept(input logic [7:0] op);
        bit srl;
        srl = sr_protect[1] || (sr_protect == 2'b01 && !wp_n);
        if (!m_pg) return 0;
        if (m_pd) return op == 8'hAB;
        if (op == 8'h06) return !m_lock;
        if (op == 8'h02 || is_erase(op)) return !m_lock && m_wel && !m_busy;
        if (op == 8'h01) return !m_lock && m_wel && !m_busy && !srl;
        if (op == 8'hB9) return !m_busy;
        return 1;
    endfunction

    // Issue one instruction; whole/hold_ok low means it must be dropped (R7, R8)
    task automatic frame(input logic [7:0] op, input bit whole, input bit hold_ok,
                         input string req);
        bit exp, used;
        used = whole && hold_ok;
        exp = model_accept(op);
        @(negedge clk);
        cmd_code = op; cmd_whole = whole; hold_n = 1'b1; cs_n = 1'b0;
        repeat (2) @(negedge clk);
        hold_n = hold_ok; cs_n = 1'b1;
        @(negedge clk);
        hold_n = 1'b1;
        if (used) begin
            chk(cmd_accept == exp, req, "accept", int'(cmd_accept), int'(exp));
            chk(cmd_reject == !exp, req, "reject", int'(cmd_reject), int'(!exp));
            if (exp) begin
                if (op == 8'h06) m_wel = 1;
                else if (op == 8'h04) m_wel = 0;
                else if (op == 8'h02 || is_erase(op) || op == 8'h01) m_busy = 1;
                else if (op == 8'hB9) m_pd = 1;
                else if (op == 8'hAB) m_pd = 0;
            end
        end else begin
            chk(!cmd_accept && !cmd_reject, req, "dropped frame pulse",
                int'({cmd_accept, cmd_reject}), 0);
        end
        chk_state(req);
        @(negedge clk);
        chk(!cmd_accept && !cmd_reject, "R11", "pulse width",
            int'({cmd_accept, cmd_reject}), 0);
    endtask

    task automatic done_pulse(input string req);
        @(negedge clk);
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
        if (m_busy && m_pg) begin
            m_busy = 0;
            m_wel = 0;
        end
        chk_state(req);
    endtask

    logic [7:0] ops [11] = '{8'h06, 8'h04, 8'h02, 8'h20, 8'h52, 8'hD8,
                             8'hC7, 8'h01, 8'hB9, 8'hAB, 8'h03};

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cmd_accept && !cmd_reject, "R11", "reset verdict",
            int'({cmd_accept, cmd_reject}), 0);
        chk_state("R1");

        // R1: power-good low rejects all
        frame(8'h06, 1, 1, "R1");
        frame(8'h03, 1, 1, "R1");

        // R2: lockout window
        @(negedge clk);
        pwr_good = 1'b1; m_pg = 1; m_lock = 1;
        frame(8'h06, 1, 1, "R2");
        frame(8'h03, 1, 1, "R2");
        frame(8'h04, 1, 1, "R2");
        repeat (LOCK) @(negedge clk);
        m_lock = 0;
        frame(8'h06, 1, 1, "R2");

        // R3/R9: latch paths
        frame(8'h04, 1, 1, "R9");
        frame(8'h02, 1, 1, "R3");
        frame(8'h20, 1, 1, "R9");

        // R10/R4: busy behaviour
        frame(8'h06, 1, 1, "R3");
        frame(8'h02, 1, 1, "R10");
        frame(8'h06, 1, 1, "R10");
        frame(8'hD8, 1, 1, "R10");
        frame(8'hB9, 1, 1, "R10");
        done_pulse("R4");
        done_pulse("R4");

        // R7/R8: dropped frames keep state
        frame(8'h06, 1, 1, "R3");
        frame(8'h04, 1, 0, "R7");
        frame(8'h04, 0, 1, "R8");
        frame(8'h01, 1, 0, "R7");

        // R5: power-down
        frame(8'hB9, 1, 1, "R5");
        frame(8'h04, 1, 1, "R5");
        frame(8'h01, 1, 1, "R5");
        frame(8'h03, 1, 1, "R5");
        frame(8'hAB, 1, 1, "R5");
        frame(8'h01, 1, 1, "R6");
        if (m_busy) done_pulse("R4");

        // R6/R12 sweep: all protect codes, pin levels and opcodes
        for (int s = 0; s < 4; s++) begin
            for (int w = 0; w < 2; w++) begin
                sr_protect = 2'(s); wp_n = w[0];
                for (int i = 0; i < 11; i++) begin
                    if (((i + s + w) % 2) == 0) frame(8'h06, 1, 1, "R3");
                    frame(ops[i], 1, 1, "R6");
                    if (m_busy) done_pulse("R4");
                    if (m_pd) frame(8'hAB, 1, 1, "R5");
                end
            end
        end

        // R1: power loss clears state, then lockout restarts
        frame(8'h06, 1, 1, "R3");
        frame(8'hB9, 1, 1, "R5");
        @(negedge clk);
        pwr_good = 1'b0; m_pg = 0;
        @(negedge clk);
        m_wel = 0; m_pd = 0; m_busy = 0;
        chk_state("R1");
        frame(8'hAB, 1, 1, "R1");
        @(negedge clk);
        pwr_good = 1'b1; m_pg = 1; m_lock = 1;
        frame(8'h06, 1, 1, "R2");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule